// File: doc/BRIEF.md
# Pseudo-SRAM Power-State Sequencer

This block owns the chip-enable line that puts a pseudo-static RAM into and out of its data-destroying deep power-down state. It holds the memory access controller off with a hold signal whenever the memory may not be touched. That covers three windows: the power-up wait after the supply is valid, the deep power-down interval itself, and the recovery interval after waking. All three durations are counted in clock cycles and set by parameters.

The host asks for deep power-down with a level request. The sequencer honours it only while the access controller reports idle, so no access is ever cut off. Before the enable line drops, there is one guard cycle in which hold is already asserted. A wake request is a one-cycle pulse. If it arrives while the minimum low time is still running, it is stored and acted on when that time expires. A sticky flag tells the host that memory contents are no longer valid. The flag is raised on power-up and on every entry into deep power-down, and only a host acknowledge clears it. All inputs are synchronous to `clk`. `rst_n` is asserted asynchronously and its release passes through a two-stage synchroniser.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is held, ce2 is 1, hold is 1, ready is 0 and lost is 1.
- R2: With pwr_good high, ready rises at the negedge following rising edge PWRUP_CYC+SYNC_STAGES after rst_n is released; ce2 stays 1 throughout.
- R3: pwr_good low in any state returns the block to the power-up wait in the next cycle: ce2 1, hold 1, ready 0, lost 1. Once pwr_good is high again, ready rises PWRUP_CYC cycles later.
- R4: A held deep power-down request is acted on only in the ready state and only while ctl_idle is 1. While ctl_idle is 0, ce2 and ready stay 1.
- R5: On entry there is one cycle with hold 1 and ce2 still 1. ce2 goes to 0 in the following cycle.
- R6: Once low, ce2 stays low for max(DPD_MIN_CYC, j) cycles, where j counts the rising edges from the fall of ce2 up to and including the edge that samples wake_req. A wake that comes early is remembered.
- R7: After ce2 returns to 1 on wake-up, hold stays 1 and ready stays 0 for exactly EXIT_CYC cycles. Then ready rises.
- R8: hold is 1 in every state except ready, and 0 in ready.
- R9: lost is set on every entry into deep power-down and while pwr_good is low. lost_ack clears it one cycle later. A set in the same cycle wins over an acknowledge.
- R10: wake_req outside the deep power-down state has no effect and is not carried into a later power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply valid |
| dpd_req | input | 1 | Level request to enter deep power-down |
| wake_req | input | 1 | One-cycle request to leave deep power-down |
| ctl_idle | input | 1 | Access controller has no access in flight |
| lost_ack | input | 1 | Host acknowledge that clears lost |
| ce2 | output | 1 | Memory power-state enable, 0 = deep power-down |
| hold | output | 1 | Blocks the access controller |
| ready | output | 1 | Memory may be accessed |
| lost | output | 1 | Sticky: memory contents invalid |

## Verification
The bench builds the block with PWRUP_CYC=20, DPD_MIN_CYC=30 and EXIT_CYC=12. With these values, every window's exact length can be measured in a few dozen cycles. Wake pulses are placed before, exactly at, one past and well beyond the end of the minimum low time, which exercises both the stored-wake path and the immediate-wake path. The same small values let the bench show that a wake pulse seen in the ready state stretches the next power-down to the full waiting time instead of cutting it short.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_PUP   = 3'd0,
    PS_READY = 3'd1,
    PS_ENTER = 3'd2,
    PS_DPD   = 3'd3,
    PS_EXIT  = 3'd4
  } pwr_state_e;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_dwell_timer.sv
module pwr_dwell_timer #(
  parameter int unsigned   CW      = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  // A fresh non-zero load must not report expiry in the next cycle (R6, R7)
  p_load_not_done_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (load && (load_val != '0)) |=> !done);

endmodule

// File: rtl/pwr_lost_flag.sv
module pwr_lost_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic q_d;
  logic q_r;

  always_comb begin
    q_d = q_r;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= 1'b1;
    end else begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    set |=> q);

  p_clear_needs_ack_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(q) |-> $past(clr));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned PWRUP_CYC   = 20,
  parameter int unsigned DPD_MIN_CYC = 30,
  parameter int unsigned EXIT_CYC    = 12
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          pwr_good,
  input  logic          dpd_req,
  input  logic          wake_req,
  input  logic          ctl_idle,
  input  logic          t_done,
  output logic          t_load,
  output logic [CW-1:0] t_load_val,
  output logic          lost_set,
  output logic          ce2_o,
  output logic          hold_o,
  output logic          ready_o
);

  localparam logic [CW-1:0] PWRUP_V = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] DPD_V   = CW'(DPD_MIN_CYC - 1);
  localparam logic [CW-1:0] EXIT_V  = CW'(EXIT_CYC - 1);

  pwr_state_e state_q, state_d;
  logic       wake_pend_q, wake_pend_d;
  logic       wake_seen;

  assign wake_seen = wake_pend_q || wake_req;

  always_comb begin
    state_d    = state_q;
    t_load     = 1'b0;
    t_load_val = PWRUP_V;
    unique case (state_q)
      PS_PUP:   if (t_done) state_d = PS_READY;
      PS_READY: if (dpd_req && ctl_idle) state_d = PS_ENTER;
      PS_ENTER: begin
        state_d    = PS_DPD;
        t_load     = 1'b1;
        t_load_val = DPD_V;
      end
      PS_DPD: begin
        if (t_done && wake_seen) begin
          state_d    = PS_EXIT;
          t_load     = 1'b1;
          t_load_val = EXIT_V;
        end
      end
      PS_EXIT:  if (t_done) state_d = PS_READY;
      default:  state_d = PS_PUP;
    endcase
    if (!pwr_good) begin
      state_d    = PS_PUP;
      t_load     = 1'b1;
      t_load_val = PWRUP_V;
    end
  end

  always_comb begin
    wake_pend_d = (state_q == PS_DPD) && (state_d == PS_DPD) && wake_seen;
    lost_set    = !pwr_good || ((state_q == PS_ENTER) && (state_d == PS_DPD));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_PUP;
      wake_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_pend_q <= wake_pend_d;
    end
  end

  assign ce2_o   = (state_q != PS_DPD);
  assign ready_o = (state_q == PS_READY);
  assign hold_o  = !ready_o;

  // Independent dwell counter used only by the checks below
  logic [CW-1:0] dwell_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dwell_q <= '0;
    end else if (state_d != state_q) begin
      dwell_q <= '0;
    end else if (dwell_q != '1) begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  p_pup_len_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PS_PUP && state_d == PS_READY) |-> (dwell_q >= PWRUP_V));

  p_dpd_min_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PS_DPD && state_d == PS_EXIT) |-> (dwell_q >= DPD_V));

  p_exit_len_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PS_EXIT && state_d == PS_READY) |-> (dwell_q >= EXIT_V));

  p_pwr_loss_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !pwr_good |=> (ce2_o && hold_o && !ready_o));

  p_fall_guarded_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ce2_o) |-> ($past(hold_o) && $past(pwr_good)));

  p_fall_idle_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ce2_o) |-> ($past(ctl_idle, 2) && $past(ready_o, 2)));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned PWRUP_CYC   = 30000,
  parameter int unsigned DPD_MIN_CYC = 1000000,
  parameter int unsigned EXIT_CYC    = 30000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic dpd_req,
  input  logic wake_req,
  input  logic ctl_idle,
  input  logic lost_ack,
  output logic ce2,
  output logic hold,
  output logic ready,
  output logic lost
);

  localparam int unsigned CW = $clog2(max3(PWRUP_CYC, DPD_MIN_CYC, EXIT_CYC) + 1);
  localparam logic [CW-1:0] PWRUP_RST = CW'(PWRUP_CYC - 1);

  logic          rst_i;
  logic          t_done;
  logic          t_load;
  logic [CW-1:0] t_load_val;
  logic          lost_set;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_i)
  );

  pwr_seq_fsm #(
    .CW          (CW),
    .PWRUP_CYC   (PWRUP_CYC),
    .DPD_MIN_CYC (DPD_MIN_CYC),
    .EXIT_CYC    (EXIT_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_ni     (rst_i),
    .pwr_good   (pwr_good),
    .dpd_req    (dpd_req),
    .wake_req   (wake_req),
    .ctl_idle   (ctl_idle),
    .t_done     (t_done),
    .t_load     (t_load),
    .t_load_val (t_load_val),
    .lost_set   (lost_set),
    .ce2_o      (ce2),
    .hold_o     (hold),
    .ready_o    (ready)
  );

  pwr_dwell_timer #(.CW(CW), .RST_VAL(PWRUP_RST)) u_timer (
    .clk      (clk),
    .rst_ni   (rst_i),
    .load     (t_load),
    .load_val (t_load_val),
    .done     (t_done)
  );

  pwr_lost_flag u_lost (
    .clk    (clk),
    .rst_ni (rst_i),
    .set    (lost_set),
    .clr    (lost_ack),
    .q      (lost)
  );

endmodule

// File: tb/psram_pwr_seq_test.sv
module psram_pwr_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 20;
  localparam int DM = 30;
  localparam int EX = 12;
  localparam int SS = 2;

  // wake delay after first low observation, acknowledge at entry, expected low length
  localparam int TBL_N = 6;
  localparam int TBL_W   [TBL_N] = '{0, 5, DM-2, DM-1, DM, DM+7};
  localparam bit TBL_ACK [TBL_N] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam int TBL_LOW [TBL_N] = '{DM, DM, DM, DM, DM+1, DM+8};

  logic clk = 1'b0;
  logic rst_n, pwr_good, dpd_req, wake_req, ctl_idle, lost_ack;
  logic ce2, hold, ready, lost;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_pwr_seq #(
    .PWRUP_CYC(PW), .DPD_MIN_CYC(DM), .EXIT_CYC(EX), .SYNC_STAGES(SS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .dpd_req(dpd_req),
    .wake_req(wake_req), .ctl_idle(ctl_idle), .lost_ack(lost_ack),
    .ce2(ce2), .hold(hold), .ready(ready), .lost(lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter_dpd(input bit ack);
    dpd_req = 1'b1;
    @(negedge clk);
    chk("R5 guard cycle hold/ce2", {30'd0, hold, ce2}, 3);
    dpd_req = 1'b0;
    lost_ack = ack;
    @(negedge clk);
    lost_ack = 1'b0;
    chk("R5 ce2 low after guard", int'(ce2), 0);
    chk("R9 lost set on entry", int'(lost), 1);
  endtask

  task automatic wake_and_exit(input int w, output int low, output int ex);
    low = 1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (!ce2) low++;
    end
    wake_req = 1'b1;
    while (1) begin
      @(negedge clk);
      wake_req = 1'b0;
      if (ce2) break;
      low++;
    end
    ex = 1;
    while (1) begin
      if (!hold || ready) break;
      @(negedge clk);
      if (ready) break;
      ex++;
    end
  endtask

  task automatic ack_lost();
    lost_ack = 1'b1;
    @(negedge clk);
    lost_ack = 1'b0;
    chk("R9 ack clears lost", int'(lost), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, low, ex;
    rst_n = 1'b0; pwr_good = 1'b1; dpd_req = 1'b0; wake_req = 1'b0;
    ctl_idle = 1'b1; lost_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ce2/hold/ready/lost", {28'd0, ce2, hold, ready, lost}, 4'b1101);

    // R2 power-up wait
    rst_n = 1'b1;
    n = 0;
    while (!ready) begin @(negedge clk); n++; end
    chk("R2 power-up cycles", n, PW + SS);
    chk("R8 hold low in ready", int'(hold), 0);
    chk("R2 ce2 high after power-up", int'(ce2), 1);
    ack_lost();

    // R10 wake in ready has no effect
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 wake in ready ignored", {30'd0, ready, ce2}, 3);

    // R4 request waits for idle
    ctl_idle = 1'b0; dpd_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i == 4) chk("R4 busy blocks entry", {30'd0, ready, ce2}, 3);
    end
    ctl_idle = 1'b1;
    enter_dpd(1'b0);
    wake_and_exit(DM + 5, low, ex);
    chk("R10 earlier wake not remembered", low, DM + 6);
    chk("R7 exit length", ex, EX);
    ack_lost();

    // R6/R7/R9 table walk
    for (int t = 0; t < TBL_N; t++) begin
      enter_dpd(TBL_ACK[t]);
      wake_and_exit(TBL_W[t], low, ex);
      chk("R6 ce2 low length", low, TBL_LOW[t]);
      chk("R7 exit length", ex, EX);
      chk("R9 lost held until ack", int'(lost), 1);
      ack_lost();
    end

    // R3 power loss during deep power-down
    enter_dpd(1'b0);
    ack_lost();
    repeat (3) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R3 loss ce2/hold/ready/lost", {28'd0, ce2, hold, ready, lost}, 4'b1101);
    repeat (10) @(negedge clk);
    chk("R3 no ready while supply low", int'(ready), 0);
    pwr_good = 1'b1;
    n = 0;
    while (!ready) begin @(negedge clk); n++; end
    chk("R3 power-up after loss", n, PW);
    chk("R8 hold low in ready", int'(hold), 0);
    ack_lost();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule